// File: doc/BRIEF.md
# Byte-wide parallel printer port handshake engine

This engine moves single bytes between a host-side valid/ready stream and an external byte-wide parallel port. It runs entirely in the system bus clock domain. All its timing is counted in periods of that clock. A direction control bit selects the mode. In output mode the engine places a byte on the data lines, waits a programmed setup time, and raises a strobe of programmed width. It then keeps the data for a programmed hold time and waits for the peripheral to acknowledge. In input mode it watches for a qualified incoming strobe, captures the data lines into a one-byte holding register, and answers with a busy pulse followed by an acknowledge pulse.

The same direction bit also sets the four external transceiver direction pins. Those pins always move in two fixed, opposite pairs. Every peripheral input passes through a two-flop synchronizer, and incoming strobe and acknowledge levels are only acted on once they have stayed high for three clocks. A sticky interrupt flag is raised whenever a byte finishes in either direction. The host clears it by writing one.

Top module: `pport_engine`

## Requirements
- R1: After reset, `strobe_o`, `busy_o`, `ack_o`, `irq_o` and `rx_valid_o` are 0 and `pd_o` is 0. The direction pins show output mode (`d_dir_o`=`stb_dir_o`=1, `busy_dir_o`=`ack_dir_o`=0), and `tx_ready_o` is 1 when `busy_i` is low.
- R2: With the applied direction at 0, `d_dir_o`=`stb_dir_o`=1 and `busy_dir_o`=`ack_dir_o`=0. With it at 1 the four pins invert. `strobe_o` never rises while the engine is in input mode.
- R3: In output mode `strobe_o` stays high for exactly 3 + `dsw_i` clocks.
- R4: An accepted byte appears on `pd_o` exactly `dss_i` + 1 clocks before `strobe_o` rises. It does not change while the strobe is high.
- R5: After `strobe_o` falls, `pd_o` keeps the byte for exactly `dsn_i` clocks and then returns to 0. `pd_o` is 0 whenever no output byte is being driven.
- R6: While `busy_i` is high, `tx_ready_o` is 0 and no new byte is started.
- R7: After an output byte, `tx_ready_o` stays 0 and no completion is signalled until `ack_i` has been high for at least 3 clocks.
- R8: In input mode, when `strobe_i` has been high for 3 clocks, the value on `pd_i` is captured and offered on `rx_data_o` with `rx_valid_o`.
- R9: An incoming `strobe_i` or `ack_i` pulse shorter than 3 clocks is ignored.
- R10: After a capture, `busy_o` is high for exactly 3 clocks. `ack_o` is then high for exactly 3 clocks, starting in the clock in which `busy_o` falls.
- R11: `irq_o` is set when a byte completes in either direction. It stays set until a clock with `irq_clr_i` high.
- R12: A change of `dir_i` while a byte is in progress has no effect on the direction pins or the mode until the engine is idle.
- R13: A captured byte is held on `rx_data_o` with `rx_valid_o` until `rx_ready_i`. `busy_o` stays high after the acknowledge pulse until the byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Requested direction: 0 output, 1 input |
| dsw_i | input | 2 | Strobe width extension in clocks |
| dss_i | input | 2 | Data setup before strobe, minus one, in clocks |
| dsn_i | input | 2 | Data hold after strobe in clocks |
| irq_clr_i | input | 1 | Write-one-to-clear of the interrupt flag |
| tx_valid_i | input | 1 | Host offers an output byte |
| tx_data_i | input | 8 | Output byte |
| tx_ready_o | output | 1 | Engine accepts the output byte |
| rx_valid_o | output | 1 | Captured input byte available |
| rx_data_o | output | 8 | Captured input byte |
| rx_ready_i | input | 1 | Host takes the input byte |
| pd_o | output | 8 | Port data lines, driven side |
| pd_i | input | 8 | Port data lines, received side |
| strobe_o | output | 1 | Outgoing data strobe |
| strobe_i | input | 1 | Incoming data strobe |
| ack_i | input | 1 | Peripheral acknowledge |
| busy_i | input | 1 | Peripheral busy |
| ack_o | output | 1 | Generated acknowledge |
| busy_o | output | 1 | Generated busy |
| d_dir_o | output | 1 | Data transceiver direction |
| stb_dir_o | output | 1 | Strobe transceiver direction |
| busy_dir_o | output | 1 | Busy transceiver direction |
| ack_dir_o | output | 1 | Acknowledge transceiver direction |
| irq_o | output | 1 | Byte-complete interrupt flag |

## Verification
Two situations are the hardest to reach: a direction change that arrives mid-byte, and an acknowledge that is too short to count. The stimulus sets up both by making the peripheral model reply late or with a two-clock pulse. The bench then raises `dir_i` while the engine still waits for the acknowledge, and samples the direction pins before and after the byte finishes. Receive back-pressure is reached by holding `rx_ready_i` low across a full capture. This shows that busy is held past the acknowledge pulse until the host takes the byte.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {TX_IDLE, TX_SETUP, TX_STB, TX_HOLD, TX_WAIT} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_BUSY, RX_ACK, RX_DRAIN} rx_st_e;

  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pport_qual.sv
module pport_qual #(
  parameter int unsigned MIN_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  localparam int unsigned QW = $clog2(MIN_W + 1);
  logic [QW-1:0] run_q;

  // saturating run length; one event per high period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!lvl_i)               run_q <= '0;
    else if (run_q != QW'(MIN_W))  run_q <= run_q + QW'(1);
  end

  assign evt_o = lvl_i && (run_q == QW'(MIN_W - 1));
endmodule

// File: rtl/pport_tx.sv
module pport_tx
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLD_W    = 2,
  parameter int unsigned STB_BASE = 3,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic [FLD_W-1:0]  dsw_i,
  input  logic [FLD_W-1:0]  dss_i,
  input  logic [FLD_W-1:0]  dsn_i,
  input  logic              ack_evt_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              strobe_o,
  output logic              idle_o,
  output logic              done_o
);
  tx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] dat_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      dat_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (valid_i && go_i) begin
          dat_q <= data_i;
          cnt_q <= CNT_W'(dss_i);
          st_q  <= TX_SETUP;
        end
        TX_SETUP: if (cnt_zero) begin
          st_q  <= TX_STB;
          cnt_q <= CNT_W'(STB_BASE - 1) + CNT_W'(dsw_i);
        end else cnt_q <= cnt_q - CNT_W'(1);
        TX_STB: if (cnt_zero) begin
          if (dsn_i == '0) st_q <= TX_WAIT;
          else begin
            st_q  <= TX_HOLD;
            cnt_q <= CNT_W'(dsn_i) - CNT_W'(1);
          end
        end else cnt_q <= cnt_q - CNT_W'(1);
        TX_HOLD: if (cnt_zero) st_q <= TX_WAIT;
                 else cnt_q <= cnt_q - CNT_W'(1);
        TX_WAIT: if (ack_evt_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign pd_o     = (st_q inside {TX_SETUP, TX_STB, TX_HOLD}) ? dat_q : '0;
  assign strobe_o = (st_q == TX_STB);
  assign ready_o  = (st_q == TX_IDLE) && go_i;
  assign idle_o   = (st_q == TX_IDLE);
  assign done_o   = (st_q == TX_WAIT) && ack_evt_i;
endmodule

// File: rtl/pport_rx.sv
module pport_rx
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PULSE_W = 3,
  parameter int unsigned CNT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_evt_i,
  input  logic [DATA_W-1:0] pd_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              idle_o,
  output logic              done_o
);
  rx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] buf_q;
  logic              vld_q;
  logic              take;

  assign take = vld_q && rx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      buf_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (take) vld_q <= 1'b0;
      case (st_q)
        RX_IDLE: if (en_i && stb_evt_i) begin
          buf_q <= pd_i;
          vld_q <= 1'b1;
          cnt_q <= CNT_W'(PULSE_W - 1);
          st_q  <= RX_BUSY;
        end
        RX_BUSY: if (cnt_q == '0) begin
          cnt_q <= CNT_W'(PULSE_W - 1);
          st_q  <= RX_ACK;
        end else cnt_q <= cnt_q - CNT_W'(1);
        RX_ACK: if (cnt_q == '0) begin
          st_q <= (vld_q && !rx_ready_i) ? RX_DRAIN : RX_IDLE;
        end else cnt_q <= cnt_q - CNT_W'(1);
        RX_DRAIN: if (!vld_q || rx_ready_i) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign rx_valid_o = vld_q;
  assign rx_data_o  = buf_q;
  assign busy_o     = (st_q == RX_BUSY) || (st_q == RX_DRAIN);
  assign ack_o      = (st_q == RX_ACK);
  assign idle_o     = (st_q == RX_IDLE);
  assign done_o     = (st_q == RX_ACK) && (cnt_q == '0);
endmodule

// File: rtl/pport_engine.sv
module pport_engine
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLD_W    = 2,
  parameter int unsigned STB_BASE = 3,
  parameter int unsigned PULSE_W  = 3,
  parameter int unsigned MIN_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic [FLD_W-1:0]  dsw_i,
  input  logic [FLD_W-1:0]  dss_i,
  input  logic [FLD_W-1:0]  dsn_i,
  input  logic              irq_clr_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] pd_o,
  input  logic [DATA_W-1:0] pd_i,
  output logic              strobe_o,
  input  logic              strobe_i,
  input  logic              ack_i,
  input  logic              busy_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic              d_dir_o,
  output logic              stb_dir_o,
  output logic              busy_dir_o,
  output logic              ack_dir_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = cnt_bits(STB_BASE + (1 << FLD_W), PULSE_W);
  localparam int unsigned NSYNC = 3;  // 0 strobe, 1 ack, 2 busy
  localparam int unsigned NQUAL = 2;  // width-qualified lanes

  logic [NSYNC-1:0] sync_q;
  logic [NQUAL-1:0] evt;
  logic dir_q, pend, tx_idle, rx_idle, tx_done, rx_done, irq_q;

  pport_sync #(.W(NSYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({busy_i, ack_i, strobe_i}), .q_o(sync_q)
  );

  for (genvar g = 0; g < NQUAL; g++) begin : g_qual
    pport_qual #(.MIN_W(MIN_W)) u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_q[g]), .evt_o(evt[g])
    );
  end

  // direction only follows dir_i while both engines rest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 dir_q <= 1'b0;
    else if (tx_idle && rx_idle) dir_q <= dir_i;
  end
  assign pend = (dir_i != dir_q);

  pport_tx #(
    .DATA_W(DATA_W), .FLD_W(FLD_W), .STB_BASE(STB_BASE), .CNT_W(CNT_W)
  ) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .go_i(!dir_q && !pend && !sync_q[2]),
    .valid_i(tx_valid_i), .data_i(tx_data_i), .ready_o(tx_ready_o),
    .dsw_i(dsw_i), .dss_i(dss_i), .dsn_i(dsn_i),
    .ack_evt_i(evt[1]), .pd_o(pd_o), .strobe_o(strobe_o),
    .idle_o(tx_idle), .done_o(tx_done)
  );

  pport_rx #(
    .DATA_W(DATA_W), .PULSE_W(PULSE_W), .CNT_W(CNT_W)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(dir_q && !pend), .stb_evt_i(evt[0]), .pd_i(pd_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i),
    .busy_o(busy_o), .ack_o(ack_o), .idle_o(rx_idle), .done_o(rx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (tx_done || rx_done) irq_q <= 1'b1;
    else if (irq_clr_i)         irq_q <= 1'b0;
  end

  assign irq_o      = irq_q;
  assign d_dir_o    = ~dir_q;
  assign stb_dir_o  = ~dir_q;
  assign busy_dir_o = dir_q;
  assign ack_dir_o  = dir_q;
endmodule

// File: rtl/pport_engine_chk.sv
module pport_engine_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_o,
  input logic [DATA_W-1:0] pd_o,
  input logic              busy_dir_o,
  input logic              d_dir_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic              irq_clr_i,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o
);
  assert_no_strobe_in_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_dir_o |-> !strobe_o);

  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && $past(strobe_o)) |-> $stable(pd_o));

  assert_ack_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(busy_o));

  assert_irq_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_dir_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o || busy_o || ack_o) |-> $stable(d_dir_o));

  assert_rx_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind pport_engine pport_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(strobe_o), .pd_o(pd_o),
  .busy_dir_o(busy_dir_o), .d_dir_o(d_dir_o), .ack_o(ack_o), .busy_o(busy_o),
  .irq_o(irq_o), .irq_clr_i(irq_clr_i), .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o)
);

// File: tb/sim_pport_engine.sv
module sim_pport_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic dir_i = 1'b0, irq_clr = 1'b0, tx_valid = 1'b0, rx_ready = 1'b1;
  logic [1:0] dsw = '0, dss = '0, dsn = '0;
  logic [7:0] tx_data = '0, pd_i = '0;
  logic strobe_i = 1'b0, ack_i = 1'b0, busy_i = 1'b0;
  logic tx_ready, rx_valid, strobe_o, ack_o, busy_o;
  logic d_dir, stb_dir, busy_dir, ack_dir, irq;
  logic [7:0] rx_data, pd_o;

  pport_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir_i), .dsw_i(dsw), .dss_i(dss), .dsn_i(dsn),
    .irq_clr_i(irq_clr), .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(rx_ready),
    .pd_o(pd_o), .pd_i(pd_i), .strobe_o(strobe_o), .strobe_i(strobe_i),
    .ack_i(ack_i), .busy_i(busy_i), .ack_o(ack_o), .busy_o(busy_o),
    .d_dir_o(d_dir), .stb_dir_o(stb_dir), .busy_dir_o(busy_dir), .ack_dir_o(ack_dir),
    .irq_o(irq)
  );

  int checks = 0, errors = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // output-side monitor: measures setup, strobe and hold windows, pops expected byte
  int ph = 0, su = 0, sw = 0, ho = 0, stb_count = 0;
  logic [7:0] seen = '0;
  task automatic tx_finish();
    logic [7:0] e;
    if (tx_exp.size() == 0) chk(1'b0, "R4 unexpected output byte", seen, 0);
    else begin
      e = tx_exp.pop_front();
      chk(seen == e, "R4 output byte", seen, e);
    end
    chk(su == int'(dss) + 1, "R4 setup clocks", su, int'(dss) + 1);
    chk(sw == 3 + int'(dsw), "R3 strobe clocks", sw, 3 + int'(dsw));
    chk(ho == int'(dsn), "R5 hold clocks", ho, int'(dsn));
    ph = 0;
  endtask

  always begin
    @(negedge clk); #2;
    case (ph)
      0: if (pd_o != 0) begin ph = 1; su = 1; sw = 0; ho = 0; seen = pd_o; end
      1: if (strobe_o) begin
           ph = 2; sw = 1; stb_count++;
           chk(pd_o == seen, "R4 data at strobe", pd_o, seen);
         end else su++;
      2: if (strobe_o) begin
           sw++;
           chk(pd_o == seen, "R4 data during strobe", pd_o, seen);
         end else if (pd_o != 0) begin ph = 3; ho = 1; end
         else tx_finish();
      default: if (pd_o != 0) ho++; else tx_finish();
    endcase
  end

  // peripheral model answering the outgoing strobe
  bit auto_ack = 1'b0;
  int ack_gap = 2, ack_len = 4;
  always begin
    @(negedge strobe_o);
    if (auto_ack) begin
      repeat (ack_gap) @(negedge clk);
      ack_i = 1'b1;
      repeat (ack_len) @(negedge clk);
      ack_i = 1'b0;
    end
  end

  // input-side monitor
  always begin
    logic [7:0] e;
    @(negedge clk); #2;
    if (rx_valid && rx_ready) begin
      if (rx_exp.size() == 0) chk(1'b0, "R8 unexpected input byte", rx_data, 0);
      else begin
        e = rx_exp.pop_front();
        chk(rx_data == e, "R8 captured byte", rx_data, e);
      end
    end
  end

  // generated pulse widths
  bit pchk = 1'b1;
  int brun = 0, arun = 0;
  always begin
    @(negedge clk); #2;
    if (busy_o) brun++;
    else begin
      if (brun > 0 && pchk) begin
        chk(brun == 3, "R10 busy width", brun, 3);
        chk(ack_o == 1'b1, "R10 ack follows busy", ack_o, 1);
      end
      brun = 0;
    end
    if (ack_o) arun++;
    else begin
      if (arun > 0) chk(arun == 3, "R10 ack width", arun, 3);
      arun = 0;
    end
  end

  task automatic send_tx(input logic [7:0] b);
    bit ok;
    tx_exp.push_back(b);
    tx_data  = b;
    tx_valid = 1'b1;
    for (int t = 0; t < 400; t++) begin
      #2; ok = tx_ready;
      @(negedge clk);
      if (ok) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_ready();
    for (int t = 0; t < 200; t++) begin
      @(negedge clk); #2;
      if (tx_ready) break;
    end
    @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    #2 chk(irq == 1'b0, "R11 irq cleared", irq, 0);
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input int w, input bit expect_byte);
    bit seen_ack = 1'b0;
    if (expect_byte) rx_exp.push_back(b);
    pd_i = b;
    cyc(1);
    strobe_i = 1'b1;
    cyc(w);
    strobe_i = 1'b0;
    if (expect_byte) begin
      for (int t = 0; t < 60; t++) begin
        #2;
        if (ack_o) seen_ack = 1'b1;
        else if (seen_ack) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    cyc(2);
    pd_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sc;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    #2;
    chk(strobe_o == 0 && busy_o == 0 && ack_o == 0, "R1 port outputs idle", {strobe_o, busy_o, ack_o}, 0);
    chk(irq == 0 && rx_valid == 0 && pd_o == 0, "R1 irq/rx/data clear", {irq, rx_valid, pd_o}, 0);
    chk({d_dir, stb_dir, busy_dir, ack_dir} == 4'b1100, "R1 R2 direction pins out", {d_dir, stb_dir, busy_dir, ack_dir}, 4'hC);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    @(negedge clk);
    auto_ack = 1'b1;

    // R3 R4 R5 minimal timing
    send_tx(8'h5A); wait_tx_ready();
    send_tx(8'hC3); wait_tx_ready();
    // R3 R4 R5 widest timing
    dsw = 2'd3; dss = 2'd2; dsn = 2'd3;
    send_tx(8'h81); wait_tx_ready();
    send_tx(8'h7E); wait_tx_ready();
    chk(irq == 1'b1, "R11 irq after output byte", irq, 1);
    clear_irq();

    // R7 completion waits for acknowledge
    dsw = 2'd0; dss = 2'd0; dsn = 2'd0;
    ack_gap = 12;
    send_tx(8'h11);
    cyc(8); #2;
    chk(tx_ready == 1'b0, "R7 no ready before ack", tx_ready, 0);
    chk(irq == 1'b0, "R7 no completion before ack", irq, 0);
    wait_tx_ready();
    chk(irq == 1'b1, "R7 completion on ack", irq, 1);
    clear_irq();

    // R9 short acknowledge ignored
    ack_gap = 2; ack_len = 2;
    send_tx(8'h22);
    cyc(30); #2;
    chk(tx_ready == 1'b0, "R9 short ack ignored", tx_ready, 0);
    chk(irq == 1'b0, "R9 short ack no irq", irq, 0);
    @(negedge clk);
    auto_ack = 1'b0;
    ack_i = 1'b1; cyc(4); ack_i = 1'b0;
    wait_tx_ready();
    chk(irq == 1'b1, "R9 long ack completes", irq, 1);
    clear_irq();
    auto_ack = 1'b1; ack_len = 4;

    // R6 busy blocks a new byte
    busy_i = 1'b1;
    cyc(4);
    sc = stb_count;
    fork send_tx(8'h33); join_none
    cyc(20); #2;
    chk(tx_ready == 1'b0, "R6 ready low while busy", tx_ready, 0);
    chk(stb_count == sc, "R6 no strobe while busy", stb_count, sc);
    @(negedge clk);
    busy_i = 1'b0;
    wait fork;
    wait_tx_ready();
    chk(stb_count == sc + 1, "R6 byte sent after busy", stb_count, sc + 1);
    clear_irq();

    // R12 direction change deferred until idle
    ack_gap = 10;
    send_tx(8'h44);
    dir_i = 1'b1;
    cyc(3); #2;
    chk(d_dir == 1'b1 && busy_dir == 1'b0, "R12 pins held mid byte", {d_dir, busy_dir}, 2'b10);
    @(negedge clk);
    for (int t = 0; t < 80; t++) begin
      @(negedge clk); #2;
      if (!d_dir) break;
    end
    chk(ph == 0 && tx_exp.size() == 0, "R12 byte finished first", tx_exp.size(), 0);
    chk({d_dir, stb_dir, busy_dir, ack_dir} == 4'b0011, "R2 direction pins in", {d_dir, stb_dir, busy_dir, ack_dir}, 4'h3);
    chk(tx_ready == 1'b0, "R2 no output accept in input mode", tx_ready, 0);
    @(negedge clk);
    clear_irq();

    // R8 R10 input capture
    sc = stb_count;
    send_rx(8'h3C, 4, 1'b1);
    chk(irq == 1'b1, "R11 irq after input byte", irq, 1);
    clear_irq();
    send_rx(8'hA5, 5, 1'b1);
    clear_irq();

    // R9 short strobe ignored
    send_rx(8'hFF, 2, 1'b0);
    cyc(15); #2;
    chk(rx_valid == 1'b0 && busy_o == 1'b0, "R9 short strobe ignored", {rx_valid, busy_o}, 0);
    @(negedge clk);

    // R13 held byte keeps busy
    rx_ready = 1'b0; pchk = 1'b0;
    send_rx(8'h66, 4, 1'b1);
    cyc(10); #2;
    chk(rx_valid == 1'b1 && rx_data == 8'h66, "R13 byte held", rx_data, 8'h66);
    chk(busy_o == 1'b1, "R13 busy while held", busy_o, 1);
    @(negedge clk);
    rx_ready = 1'b1;
    cyc(3); #2;
    chk(busy_o == 1'b0 && rx_valid == 1'b0, "R13 released after take", {busy_o, rx_valid}, 0);
    chk(stb_count == sc, "R2 no strobe in input mode", stb_count, sc);
    chk(tx_exp.size() == 0 && rx_exp.size() == 0, "R8 all bytes seen", tx_exp.size() + rx_exp.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule